// File: doc/BRIEF.md
# Load-Link Commit Flag Unit

This unit arbitrates lock-free read-modify-write access to one shared memory location among several cores. It keeps two flags: a binary commit flag that grants exclusive write-back, and a saturating link count that records whether copies loaded earlier are still current. Each core has a request bit and a 2-bit operation field. The unit serialises requests with a round-robin arbiter, executes one operation per clock, and returns a one-cycle grant pulse together with a shared result bit.

A core first issues a load-link and then reads the shared data. Next it issues a commit. If the result bit is 1, the core holds the write-back right. It writes the data and then issues a restore. If the commit fails, the core issues a new load-link and tries again. The shared storage and the bus path to it are outside the unit.

Top module: `llc_flag_unit`

## Requirements
- R1: After reset the commit flag is 1, the link count is 0 and no grant is asserted.
- R2: A load-link (op code 0) always returns result 1. If the commit flag is 1 and the link count is above 0, the load-link lowers the link count by one. Otherwise it leaves both flags unchanged.
- R3: A commit (op code 1) issued while the commit flag is 0 returns result 0 and changes no flag.
- R4: A commit issued while the commit flag is 1 and the link count is 0 returns result 1 and clears the commit flag.
- R5: A commit issued while the commit flag is 1 and the link count is above 0 returns result 0. Both flags keep their values, because the flag that was taken is given back.
- R6: A restore (op code 2) returns result 1, sets the commit flag, and raises the link count by one, holding at LINK_MAX.
- R7: A request present at a rising edge is answered by a grant that is high for exactly one cycle after that edge, with at most one grant bit set. The result bit is valid in the same cycle as the grant. A core whose grant is high at an edge is not granted at that edge.
- R8: When several cores request at once, the grant goes to the first requesting core found after the most recently granted core, in ascending index order, wrapping after the last core.
- R9: An idle operation (op code 3) is granted, returns result 0 and changes no flag. The result bit is 0 whenever no grant is high.
- R10: The flags change only at an edge that produces a grant.
- R11: Seven cores that repeatedly load, commit and restore drive a shared counter up to 100. No two commits succeed without a restore between them, and every success is followed by exactly one restore.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CORES | Per-core request, held until the grant is seen |
| op_i | input | 2*N_CORES | Per-core operation code, core k in bits [2k+1:2k] |
| gnt_o | output | N_CORES | One-cycle grant pulse per core |
| ok_o | output | 1 | Result of the granted operation |
| commit_flag_o | output | 1 | Current commit flag |
| link_cnt_o | output | $clog2(LINK_MAX+1) | Current link count |

## Verification
The bench drives a commit from reset, a second commit while the flag is taken, and a load-link while the flag is clear. A unit that skipped the flag test in either commit case would report two successes without a restore. It also drives repeated restores past LINK_MAX and load-links below zero. A count without saturation would wrap and turn a stale commit into a success. A commit against a non-zero link count must return 0 and still leave the flag set. If the flag were not given back, every core would then be locked out.

All seven cores are then released in the same cycle. A pointer that failed to advance would favour one core, and a missing grant mask would serve the same core twice. The random counter run compares every grant and result against a reference model.

// File: rtl/llc_pkg.sv
package llc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_COMMIT  = 2'd1,
    OP_RESTORE = 2'd2,
    OP_IDLE    = 2'd3
  } llc_op_e;
endpackage

// File: rtl/llc_rr_arb.sv
module llc_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  int unsigned   cand;

  // search starts at the core after the last winner
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    cand    = 0;
    for (int k = 0; k < N; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (!valid_o && req_i[cand]) begin
        valid_o = 1'b1;
        idx_o   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (valid_o) ptr_q <= (idx_o == IW'(N-1)) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/llc_flag_core.sv
module llc_flag_core
  import llc_pkg::*;
#(
  parameter int LINK_MAX = 15,
  localparam int LW = $clog2(LINK_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  llc_op_e       op_i,
  output logic          ok_o,
  output logic          commit_o,
  output logic [LW-1:0] link_o
);
  logic          commit_q, commit_d;
  logic [LW-1:0] link_q, link_d;

  always_comb begin
    commit_d = commit_q;
    link_d   = link_q;
    ok_o     = 1'b0;
    if (valid_i) begin
      case (op_i)
        OP_LOAD: begin
          ok_o = 1'b1;
          // invalidate older copies unless a writer holds the flag
          if (commit_q && link_q != '0) link_d = link_q - 1'b1;
        end
        OP_COMMIT: begin
          // take-and-give-back on stale load leaves commit_q as is
          if (commit_q && link_q == '0) begin
            ok_o     = 1'b1;
            commit_d = 1'b0;
          end
        end
        OP_RESTORE: begin
          ok_o     = 1'b1;
          commit_d = 1'b1;
          if (link_q != LW'(LINK_MAX)) link_d = link_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b1;
      link_q   <= '0;
    end else begin
      commit_q <= commit_d;
      link_q   <= link_d;
    end
  end

  assign commit_o = commit_q;
  assign link_o   = link_q;
endmodule

// File: rtl/llc_flag_unit.sv
module llc_flag_unit
  import llc_pkg::*;
#(
  parameter int N_CORES  = 8,
  parameter int LINK_MAX = 15,
  localparam int LW = $clog2(LINK_MAX + 1),
  localparam int IW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CORES-1:0]   req_i,
  input  logic [2*N_CORES-1:0] op_i,
  output logic [N_CORES-1:0]   gnt_o,
  output logic                 ok_o,
  output logic                 commit_flag_o,
  output logic [LW-1:0]        link_cnt_o
);
  logic [N_CORES-1:0] gnt_q, elig;
  logic               ok_q, win_valid, win_ok;
  logic [IW-1:0]      win_idx;
  llc_op_e            win_op;

  // a core seeing its grant now may still hold req_i this edge
  assign elig = req_i & ~gnt_q;

  llc_rr_arb #(.N(N_CORES)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  assign win_op = llc_op_e'(op_i[2*win_idx +: 2]);

  llc_flag_core #(.LINK_MAX(LINK_MAX)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (win_valid),
    .op_i    (win_op),
    .ok_o    (win_ok),
    .commit_o(commit_flag_o),
    .link_o  (link_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      gnt_q <= '0;
      if (win_valid) gnt_q[win_idx] <= 1'b1;
      ok_q  <= win_valid & win_ok;
    end
  end

  assign gnt_o = gnt_q;
  assign ok_o  = ok_q;
endmodule

// File: rtl/llc_flag_unit_chk.sv
module llc_flag_unit_chk #(
  parameter int N_CORES  = 8,
  parameter int LINK_MAX = 15,
  localparam int LW = $clog2(LINK_MAX + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CORES-1:0] req_i,
  input logic [N_CORES-1:0] gnt_o,
  input logic               ok_o,
  input logic               commit_flag_o,
  input logic [LW-1:0]      link_cnt_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R7
  AST_GNT_HAD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (($past(req_i) & gnt_o) != '0)); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> ((gnt_o & $past(gnt_o)) == '0)); // R7
  AST_LINK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(link_cnt_o) <= LINK_MAX); // R6
  AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|gnt_o) |-> ($stable(link_cnt_o) && $stable(commit_flag_o))); // R10
  AST_FLAG_FALL_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(commit_flag_o) |-> ok_o); // R4
  AST_LINK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(link_cnt_o) |-> (link_cnt_o == $past(link_cnt_o) + 1'b1 ||
                              link_cnt_o == $past(link_cnt_o) - 1'b1)); // R2
  AST_OK_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (|gnt_o)); // R9
endmodule

bind llc_flag_unit llc_flag_unit_chk #(
  .N_CORES (N_CORES),
  .LINK_MAX(LINK_MAX)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .gnt_o        (gnt_o),
  .ok_o         (ok_o),
  .commit_flag_o(commit_flag_o),
  .link_cnt_o   (link_cnt_o)
);

// File: tb/test_llc_flag_unit.sv
module test_llc_flag_unit;
  localparam int N    = 7;
  localparam int LMAX = 3;
  localparam int LW   = $clog2(LMAX + 1);

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   req = '0;
  logic [2*N-1:0] op = '0;
  logic [N-1:0]   gnt;
  logic           ok;
  logic           cf;
  logic [LW-1:0]  lc;

  always #10 clk = ~clk;

  llc_flag_unit #(.N_CORES(N), .LINK_MAX(LMAX)) i_llc_flag_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .op_i(op),
    .gnt_o(gnt), .ok_o(ok), .commit_flag_o(cf), .link_cnt_o(lc)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit c, input string rq, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int rr_pick(input logic [N-1:0] e, input int p);
    for (int k = 0; k < N; k++) if (e[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  // reference model
  int m_link = 0, m_ptr = 0;
  bit m_commit = 1;
  bit mon_en = 0;
  logic [N-1:0]   c_req = '0, c_gnt = '0;
  logic [2*N-1:0] c_op = '0;

  always @(posedge clk) begin
    c_req <= req;
    c_op  <= op;
    c_gnt <= gnt;
  end

  always @(negedge clk) begin
    int w;
    bit eok;
    logic [1:0] o;
    string tg;
    if (mon_en) begin
      w = rr_pick(c_req & ~c_gnt, m_ptr);
      if (w < 0) begin
        chk(gnt == '0, "R7 no grant without request", int'(gnt), 0);
        chk(ok == 1'b0, "R9 result low without grant", int'(ok), 0);
      end else begin
        chk(gnt == (N'(1) << w), "R8 round-robin winner", int'(gnt), 1 << w);
        m_ptr = (w + 1) % N;
        o = c_op[2*w +: 2];
        eok = 0;
        tg = "R9 idle";
        case (o)
          2'd0: begin tg = "R2 load"; eok = 1; if (m_commit && m_link > 0) m_link--; end
          2'd1: begin
            if (!m_commit) tg = "R3 commit flag taken";
            else if (m_link == 0) begin tg = "R4 commit ok"; eok = 1; m_commit = 0; end
            else tg = "R5 commit stale";
          end
          2'd2: begin tg = "R6 restore"; eok = 1; m_commit = 1; if (m_link < LMAX) m_link++; end
          default: ;
        endcase
        chk(ok == eok, tg, int'(ok), int'(eok));
      end
      chk(cf == m_commit, "R4 commit flag state", int'(cf), int'(m_commit));
      chk(int'(lc) == m_link, "R2 link count state", int'(lc), m_link);
    end
  end

  task automatic do_op(input int k, input logic [1:0] o, output bit r);
    @(negedge clk);
    req[k] = 1'b1;
    op[2*k +: 2] = o;
    do @(negedge clk); while (!gnt[k]);
    r = ok;
    req[k] = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL R11 watchdog expired actual=1 expected=0");
    finish_run();
  end

  // random-phase core state
  int st[N], dly[N], loc[N];
  int cnt = 0, succ = 0, rest = 0, holder = -1;

  initial begin
    bit r;
    int order[N];
    int n_done;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(cf == 1'b1, "R1 reset commit flag", int'(cf), 1);
    chk(lc == '0, "R1 reset link count", int'(lc), 0);
    chk(gnt == '0, "R1 reset grants", int'(gnt), 0);
    mon_en = 1;

    do_op(0, 2'd1, r); chk(r == 1, "R4 first commit succeeds", int'(r), 1);
    chk(cf == 0, "R4 flag cleared", int'(cf), 0);
    do_op(0, 2'd1, r); chk(r == 0, "R3 second commit fails", int'(r), 0);
    do_op(0, 2'd0, r); chk(lc == 0, "R2 load with flag clear", int'(lc), 0);
    for (int i = 0; i < LMAX + 2; i++) do_op(0, 2'd2, r);
    chk(int'(lc) == LMAX, "R6 link saturates", int'(lc), LMAX);
    do_op(0, 2'd1, r); chk(r == 0, "R5 stale commit fails", int'(r), 0);
    chk(cf == 1, "R5 flag given back", int'(cf), 1);
    for (int i = 0; i < LMAX + 1; i++) do_op(0, 2'd0, r);
    chk(lc == 0, "R2 link floors at zero", int'(lc), 0);
    do_op(0, 2'd3, r); chk(r == 0, "R9 idle result", int'(r), 0);

    // all cores at once: rotation starts after core 0
    @(negedge clk);
    for (int k = 0; k < N; k++) op[2*k +: 2] = 2'd0;
    req = '1;
    n_done = 0;
    while (n_done < N) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) if (gnt[k]) begin
        order[n_done] = k;
        n_done++;
        req[k] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++)
      chk(order[i] == (1 + i) % N, "R8 grant order", order[i], (1 + i) % N);

    // random counter run
    for (int k = 0; k < N; k++) begin st[k] = 0; dly[k] = $urandom_range(0, 3); end
    for (int cyc = 0; cyc < 40000; cyc++) begin
      bit all_idle;
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        if (gnt[k]) begin
          case (st[k])
            1: begin loc[k] = cnt; st[k] = 2; end
            2: if (ok) begin
                 succ++;
                 chk(holder < 0, "R11 exclusive write-back", holder, -1);
                 holder = k;
                 cnt = loc[k] + 1;
                 st[k] = 3;
               end else st[k] = 1;
            3: begin holder = -1; rest++; st[k] = 0; dly[k] = $urandom_range(0, 3); end
            default: ;
          endcase
        end else if (st[k] == 0 && cnt < 100) begin
          if (dly[k] == 0) st[k] = 1; else dly[k]--;
        end
        req[k] = (st[k] != 0);
        op[2*k +: 2] = (st[k] == 2) ? 2'd1 : (st[k] == 3) ? 2'd2 : 2'd0;
      end
      all_idle = 1;
      for (int k = 0; k < N; k++) if (st[k] != 0) all_idle = 0;
      if (all_idle && cnt >= 100) break;
    end
    repeat (3) @(negedge clk);
    chk(cnt >= 100, "R11 counter reached target", cnt, 100);
    chk(rest == succ, "R11 one restore per success", rest, succ);
    chk(succ >= 100, "R11 success count", succ, 100);
    finish_run();
  end
endmodule